// File: doc/BRIEF.md
# I2C Byte-Addressed RAM Target

This block is a target device on a two-wire serial bus. It contains a byte-wide memory (256 locations by default) that the bus controller reaches through an 8-bit word pointer. In a write transfer, the controller sends the device address with the direction bit clear. The next byte loads the pointer. Every byte after that is stored at the pointer, and the pointer then moves on by one. Reads return bytes from the pointer onwards. The controller acknowledges each byte it wants to continue past and leaves the ninth bit high on the last one.

To read from a chosen location, the controller first writes only the word address. It then issues a repeated START followed by the device address with the direction bit set. A current-address read skips the first phase and continues from wherever the pointer was left, including across a STOP. The bus pins are sampled through synchronizers in the block clock domain. The data line is driven open-drain: the single output only ever pulls the line low.

Top module: `i2c_ram_target`

## Requirements
- R1: After a START, a byte whose upper seven bits equal DEV_ADDR (default 7'h50) is acknowledged with SDA low on the ninth clock; bit 0 of that byte selects the direction (0 = write, 1 = read).
- R2: A target that sees a non-matching device address never pulls SDA until a STOP, including across a repeated START with its own address; bytes sent meanwhile leave the memory unchanged.
- R3: In a write transfer, the first byte after the device address loads the word pointer, is acknowledged and is not stored.
- R4: Each further written byte is stored at the pointer and acknowledged, and the pointer advances by one per byte written or read, so a multi-byte transfer covers consecutive locations.
- R5: The pointer wraps from 8'hFF to 8'h00.
- R6: A repeated START with the read address after a word-address write returns the byte at that word address, MSB first.
- R7: A low ninth bit from the controller during a read continues with the next location; a high ninth bit ends the read, and the target then leaves SDA released for any further clocks.
- R8: A STOP returns the target to idle but keeps the pointer, so a current-address read resumes from it.
- R9: While reset is held SDA is released, and the pointer restarts at 0 after reset; memory contents survive reset.
- R10: The target changes its SDA drive only while SCL is low; each read byte is fetched from memory before its first bit is driven.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock, much faster than SCL |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_pull_o | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
The assertions assume the bus is clean: SCL and SDA never change within the same synchronized sample, and each level is held for several block clocks so that every edge is seen. They also assume the controller moves SDA only while SCL is low, except to form START and STOP. The bench controller holds every bus level for eight block clocks, and it changes SDA in a separate step from any SCL edge. It never releases SCL while the target may still be changing its drive.

// File: rtl/i2c_ram_pkg.sv
package i2c_ram_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_WORD,
    ST_WORD_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RACK,
    ST_WAIT
  } tgt_state_e;
endpackage

// File: rtl/i2c_ram_edge.sv
module i2c_ram_edge #(
  parameter int unsigned SYNC_W = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC_W-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[SYNC_W-2:0], scl_i};
      sda_ff <= {sda_ff[SYNC_W-2:0], sda_i};
      scl_q  <= scl_ff[SYNC_W-1];
      sda_q  <= sda_ff[SYNC_W-1];
    end
  end

  assign scl_o      = scl_ff[SYNC_W-1];
  assign sda_o      = sda_ff[SYNC_W-1];
  assign scl_rise_o = scl_o & ~scl_q;
  assign scl_fall_o = ~scl_o & scl_q;
  // data edges while clock is high and steady
  assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/i2c_ram_store.sv
module i2c_ram_store #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/i2c_ram_ctrl.sv
module i2c_ram_ctrl
  import i2c_ram_pkg::*;
#(
  parameter int unsigned AW       = 8,
  parameter logic [6:0]  DEV_ADDR = 7'h50
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  output logic              we_o,
  output logic [AW-1:0]     ptr_o,
  output logic [BYTE_W-1:0] wdata_o,
  input  logic [BYTE_W-1:0] rdata_i,
  output logic              sda_pull_o
);
  localparam int unsigned CNT_W = $clog2(BYTE_W + 1);

  tgt_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] sh_q, sh_d, tx_q, tx_d;
  logic [AW-1:0]     ptr_q, ptr_d;
  logic              rw_q, rw_d, mack_q, mack_d;
  logic              pull_q, pull_d, we;
  logic              rx_state, byte_done;

  assign rx_state  = (state_q == ST_DEV) || (state_q == ST_WORD) || (state_q == ST_WDATA);
  assign byte_done = scl_fall_i && (cnt_q == CNT_W'(BYTE_W));

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    tx_d    = tx_q;
    ptr_d   = ptr_q;
    rw_d    = rw_q;
    mack_d  = mack_q;
    we      = 1'b0;
    if (stop_i) begin
      state_d = ST_IDLE;
    end else if (start_i && state_q != ST_WAIT) begin
      state_d = ST_DEV;
      cnt_d   = '0;
    end else if (rx_state) begin
      if (scl_rise_i) begin
        sh_d  = {sh_q[BYTE_W-2:0], sda_i};
        cnt_d = cnt_q + 1'b1;
      end
      if (byte_done) begin
        cnt_d = '0;
        unique case (state_q)
          ST_DEV: begin
            if (sh_q[BYTE_W-1:1] == DEV_ADDR) begin
              state_d = ST_DEV_ACK;
              rw_d    = sh_q[0];
            end else begin
              state_d = ST_WAIT;
            end
          end
          ST_WORD: begin
            ptr_d   = sh_q[AW-1:0];
            state_d = ST_WORD_ACK;
          end
          default: begin
            we      = 1'b1;
            ptr_d   = ptr_q + 1'b1;
            state_d = ST_WDATA_ACK;
          end
        endcase
      end
    end else begin
      unique case (state_q)
        ST_DEV_ACK: if (scl_fall_i) begin
          if (rw_q) begin
            tx_d    = rdata_i;
            ptr_d   = ptr_q + 1'b1;
            state_d = ST_RDATA;
          end else begin
            state_d = ST_WORD;
          end
        end
        ST_WORD_ACK, ST_WDATA_ACK: if (scl_fall_i) state_d = ST_WDATA;
        ST_RDATA: if (scl_fall_i) begin
          tx_d  = {tx_q[BYTE_W-2:0], 1'b1};
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == CNT_W'(BYTE_W - 1)) begin
            cnt_d   = '0;
            state_d = ST_RACK;
          end
        end
        ST_RACK: begin
          if (scl_rise_i) mack_d = ~sda_i;
          if (scl_fall_i) begin
            if (mack_q) begin
              tx_d    = rdata_i;
              ptr_d   = ptr_q + 1'b1;
              state_d = ST_RDATA;
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    pull_d = 1'b0;
    if (state_d == ST_DEV_ACK || state_d == ST_WORD_ACK || state_d == ST_WDATA_ACK)
      pull_d = 1'b1;
    else if (state_d == ST_RDATA)
      pull_d = ~tx_d[BYTE_W-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      tx_q    <= '1;
      ptr_q   <= '0;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
      pull_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      tx_q    <= tx_d;
      ptr_q   <= ptr_d;
      rw_q    <= rw_d;
      mack_q  <= mack_d;
      pull_q  <= pull_d;
    end
  end

  assign we_o       = we;
  assign ptr_o      = ptr_q;
  assign wdata_o    = sh_q;
  assign sda_pull_o = pull_q;

  // R10: drive only moves while the synchronized clock is low
  a_r10_pull_moves_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pull_q) |-> !scl_i);

  // R2: an unselected target stays silent
  a_r2_wait_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT) |-> !pull_q);

  // R7: controller owns the ninth bit of a read
  a_r7_rack_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RACK) |-> !pull_q);

  // R4: each stored byte advances the pointer by one
  a_r4_ptr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we |=> (ptr_q == $past(ptr_q) + 1'b1));

  // R8: a STOP never disturbs the pointer
  a_r8_stop_keeps_ptr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> $stable(ptr_q));
endmodule

// File: rtl/i2c_ram_target.sv
module i2c_ram_target #(
  parameter int unsigned AW       = 8,
  parameter logic [6:0]  DEV_ADDR = 7'h50,
  parameter int unsigned SYNC_W   = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_pull_o
);
  import i2c_ram_pkg::*;

  logic scl_s, sda_s, scl_rise, scl_fall, start, stop;
  logic              we;
  logic [AW-1:0]     ptr;
  logic [BYTE_W-1:0] wdata, rdata;

  i2c_ram_edge #(.SYNC_W(SYNC_W)) u_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_o      (scl_s),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start),
    .stop_o     (stop)
  );

  i2c_ram_ctrl #(.AW(AW), .DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_s),
    .sda_i      (sda_s),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start),
    .stop_i     (stop),
    .we_o       (we),
    .ptr_o      (ptr),
    .wdata_o    (wdata),
    .rdata_i    (rdata),
    .sda_pull_o (sda_pull_o)
  );

  i2c_ram_store #(.AW(AW), .DW(BYTE_W)) u_store (
    .clk_i   (clk_i),
    .we_i    (we),
    .waddr_i (ptr),
    .wdata_i (wdata),
    .raddr_i (ptr),
    .rdata_o (rdata)
  );
endmodule

// File: tb/i2c_ram_target_tb.sv
module i2c_ram_target_tb;
  localparam int unsigned QC     = 8;
  localparam logic [7:0]  ADDR_W = 8'hA0;
  localparam logic [7:0]  ADDR_R = 8'hA1;
  localparam logic [7:0]  BAD_W  = 8'hA4;
  localparam int unsigned NVEC   = 4;
  // {word address, first byte, second byte}
  localparam logic [23:0] VEC [NVEC] = '{
    24'h10_3C_C3, 24'h7F_5A_A5, 24'hFF_11_22, 24'h80_E7_18
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic pull;
  logic sda_bus;
  int   checks = 0;
  int   failures = 0;
  logic pull_prev = 1'b0;

  always #2 clk = ~clk;

  assign sda_bus = m_sda & ~pull;

  i2c_ram_target u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .scl_i      (m_scl),
    .sda_i      (sda_bus),
    .sda_pull_o (pull)
  );

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R10 monitor: drive must not move while SCL is high
  always @(negedge clk) begin
    if (rst_n && pull != pull_prev && m_scl)
      chk(1'b0, "R10 pull moved with scl high", {7'd0, pull}, {7'd0, pull_prev});
    pull_prev <= pull;
  end

  task automatic q();
    repeat (QC) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    m_sda = 1'b1; q();
    m_scl = 1'b1; q();
    m_sda = 1'b0; q();
    m_scl = 1'b0; q();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; q();
    m_scl = 1'b1; q();
    m_sda = 1'b1; q();
  endtask

  task automatic wr_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; q();
      m_scl = 1'b1; q();
      m_scl = 1'b0; q();
    end
    m_sda = 1'b1; q();
    m_scl = 1'b1; q();
    ack = !sda_bus;
    m_scl = 1'b0; q();
  endtask

  task automatic rd_byte(input bit mack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      q();
      m_scl = 1'b1; q();
      b[i] = sda_bus;
      m_scl = 1'b0;
    end
    q();
    m_sda = mack ? 1'b0 : 1'b1; q();
    m_scl = 1'b1; q();
    m_scl = 1'b0; q();
    m_sda = 1'b1;
  endtask

  initial begin
    bit ack;
    logic [7:0] d;

    // reset state
    repeat (5) @(posedge clk); #1;
    chk(pull == 1'b0, "R9 released in reset", {7'd0, pull}, 8'h00);
    rst_n = 1'b1; q();

    // seed location 0, reset, then current-address read
    bus_start();
    wr_byte(ADDR_W, ack); chk(ack, "R1 address ack", {7'd0, ack}, 8'h01);
    wr_byte(8'h00, ack);  chk(ack, "R3 word ack", {7'd0, ack}, 8'h01);
    wr_byte(8'hA5, ack);  chk(ack, "R4 data ack", {7'd0, ack}, 8'h01);
    bus_stop();
    rst_n = 1'b0; repeat (3) @(posedge clk); #1;
    chk(pull == 1'b0, "R9 released in reset", {7'd0, pull}, 8'h00);
    rst_n = 1'b1; q();
    bus_start();
    wr_byte(ADDR_R, ack); chk(ack, "R1 read address ack", {7'd0, ack}, 8'h01);
    rd_byte(1'b0, d);     chk(d == 8'hA5, "R9 pointer zero after reset", d, 8'hA5);
    bus_stop();

    // vector table: two-byte write then random read
    for (int v = 0; v < NVEC; v++) begin
      bus_start();
      wr_byte(ADDR_W, ack);        chk(ack, "R1 address ack", {7'd0, ack}, 8'h01);
      wr_byte(VEC[v][23:16], ack); chk(ack, "R3 word ack", {7'd0, ack}, 8'h01);
      wr_byte(VEC[v][15:8], ack);  chk(ack, "R4 first data ack", {7'd0, ack}, 8'h01);
      wr_byte(VEC[v][7:0], ack);   chk(ack, "R4 second data ack", {7'd0, ack}, 8'h01);
      bus_stop();
      bus_start();
      wr_byte(ADDR_W, ack);
      wr_byte(VEC[v][23:16], ack);
      bus_start();
      wr_byte(ADDR_R, ack); chk(ack, "R6 read address ack", {7'd0, ack}, 8'h01);
      rd_byte(1'b1, d);     chk(d == VEC[v][15:8], "R6 random read", d, VEC[v][15:8]);
      rd_byte(1'b0, d);     chk(d == VEC[v][7:0], "R4 R5 consecutive read", d, VEC[v][7:0]);
      bus_stop();
    end

    // R5: location 0 now holds the wrapped byte
    bus_start();
    wr_byte(ADDR_W, ack); wr_byte(8'h00, ack);
    bus_start();
    wr_byte(ADDR_R, ack);
    rd_byte(1'b0, d); chk(d == 8'h22, "R5 wrap landed at 00", d, 8'h22);
    bus_stop();

    // R2: wrong address, then own address after repeated START
    bus_start();
    wr_byte(BAD_W, ack);  chk(!ack, "R2 no ack on other address", {7'd0, ack}, 8'h00);
    wr_byte(8'h10, ack);  chk(!ack, "R2 no ack while inactive", {7'd0, ack}, 8'h00);
    bus_start();
    wr_byte(ADDR_W, ack); chk(!ack, "R2 repeated START ignored", {7'd0, ack}, 8'h00);
    wr_byte(8'h10, ack);
    wr_byte(8'h99, ack);  chk(!ack, "R2 data ignored", {7'd0, ack}, 8'h00);
    bus_stop();
    bus_start();
    wr_byte(ADDR_W, ack); chk(ack, "R2 active again after STOP", {7'd0, ack}, 8'h01);
    wr_byte(8'h10, ack);
    bus_start();
    wr_byte(ADDR_R, ack);
    rd_byte(1'b0, d); chk(d == 8'h3C, "R2 memory unchanged", d, 8'h3C);
    bus_stop();

    // R8 + R7: set pointer, STOP, current-address read, ack chain, NACK
    bus_start();
    wr_byte(ADDR_W, ack); wr_byte(8'h7F, ack);
    bus_stop();
    bus_start();
    wr_byte(ADDR_R, ack);
    rd_byte(1'b1, d); chk(d == 8'h5A, "R8 pointer kept across STOP", d, 8'h5A);
    rd_byte(1'b1, d); chk(d == 8'hE7, "R7 ack continues", d, 8'hE7);
    rd_byte(1'b0, d); chk(d == 8'h18, "R7 last byte", d, 8'h18);
    rd_byte(1'b0, d); chk(d == 8'hFF, "R7 released after NACK", d, 8'hFF);
    bus_stop();
    chk(pull == 1'b0, "R7 idle after STOP", {7'd0, pull}, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=%h expected=%h", 8'h01, 8'h00);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule